// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps wall-clock time and a calendar as packed BCD fields: seconds, minutes, hours (24-hour), day of week, date, month, two-digit year and a two-digit century. A binary prescaler counts oscillator-rate enable pulses and produces one tick per second. Each tick ripples through a chain of BCD fields. Every field returns to its floor value when it is equal to its own maximum, and passes a carry to the next field. The last legal date of the month is worked out from the current month and year, so month lengths and leap years need no outside help.

The host can stop the oscillator path. This freezes the prescaler, and so the whole calendar, without losing any state. The host can load every field at once from a set of holding inputs, which also restarts the prescaler so that a full second passes before the first tick. A frequency-test mode replaces the least significant bit of the seconds output with a square wave taken from the prescaler. With the default prescaler width this wave runs at 512 Hz.

Top module: `bcd_rtc_core`

## Requirements
- R1: Reset sets seconds, minutes, hours, year and century to 00, sets day of week, date and month to 01, and clears the prescaler.
- R2: Seconds and minutes count in BCD. Each goes from 59 back to 00 and sends a carry on the same tick. Minutes advance only when seconds wrap.
- R3: Hours count 00 to 23. A wrap from 23 to 00 advances both the date and the day of week.
- R4: While `osc_stop` is 1 no tick occurs and every field and the prescaler hold their values. When `osc_stop` returns to 0, counting resumes from the held prescaler count.
- R5: While `freq_test` is 1 and `osc_stop` is 0, bit 0 of `sec_o` carries prescaler count bit PRE_W-10. This bit toggles every 2^(PRE_W-10) enables, which gives 512 Hz from a 32768 Hz enable. In all other cases bit 0 of `sec_o` is the true seconds bit.
- R6: Months 04, 06, 09 and 11 end after date 30. Months 01, 03, 05, 07, 08, 10 and 12 end after date 31. The date then returns to 01 and the month advances.
- R7: February ends after date 29 when the BCD year is divisible by 4, year 00 included, and after date 28 otherwise.
- R8: Day of week counts 01 to 07 and goes from 07 back to 01 on the same tick as the date advance.
- R9: A `load` pulse writes all eight fields from the `ld_*` inputs on the next clock edge. It takes priority over a tick in the same cycle, and it clears the prescaler, so the next tick comes exactly 2^PRE_W enables later.
- R10: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and advances the century. Century 39 wraps to 00.
- R11: Loaded values are not range-checked. A field wraps only when it equals its maximum, and otherwise increments in BCD (ones digit 9 becomes 0 and the tens digit rises by one). For example, a loaded hour of 24 advances to 25.
- R12: Cycles with `osc_en` at 0 do not advance the prescaler. One second is exactly 2^PRE_W cycles with `osc_en` at 1, however they are spaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | Oscillator-rate enable, one pulse per oscillator period |
| osc_stop | input | 1 | Freezes the prescaler and the calendar while 1 |
| freq_test | input | 1 | Puts the prescaler square wave on bit 0 of the seconds output |
| load | input | 1 | Parallel load strobe for all fields |
| ld_sec | input | 8 | BCD seconds to load |
| ld_min | input | 8 | BCD minutes to load |
| ld_hour | input | 8 | BCD hours to load |
| ld_dow | input | 8 | BCD day of week to load |
| ld_date | input | 8 | BCD date to load |
| ld_month | input | 8 | BCD month to load |
| ld_year | input | 8 | BCD year to load |
| ld_cent | input | 8 | BCD century to load |
| sec_o | output | 8 | BCD seconds (bit 0 replaced in test mode) |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | BCD hours, 24-hour |
| dow_o | output | 8 | BCD day of week |
| date_o | output | 8 | BCD date |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |
| cent_o | output | 8 | BCD century |

## Verification
On every cycle, the checker confirms that the fields hold still without a tick or a load, that a stopped oscillator never produces a tick, and that a load writes the holding values and leaves the prescaler with no tick pending. It also checks that seconds wrap from 59 to 00, and that a tick at 23:59:59 changes both the day of week and the date. Month lengths, the leap-year rule, year and century wraps, resume after stop, the test-mode square wave, unchecked out-of-range loads and gapped enables can only be shown by the bench's scenarios. Those scenarios compare every output against a reference model on every cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef logic [7:0] bcd_t;

  localparam int NF      = 8;
  localparam int F_SEC   = 0;
  localparam int F_MIN   = 1;
  localparam int F_HOUR  = 2;
  localparam int F_DOW   = 3;
  localparam int F_DATE  = 4;
  localparam int F_MONTH = 5;
  localparam int F_YEAR  = 6;
  localparam int F_CENT  = 7;

  // value used at reset and after a wrap
  localparam bcd_t FLOOR_TBL [NF] = '{8'h00, 8'h00, 8'h00, 8'h01,
                                      8'h01, 8'h01, 8'h00, 8'h00};
  // maximum of each field; the date entry is replaced at run time
  localparam bcd_t LAST_TBL  [NF] = '{8'h59, 8'h59, 8'h23, 8'h07,
                                      8'h31, 8'h12, 8'h99, 8'h39};

  // divisibility of a two-digit BCD value by 4: 10*t + o is a multiple of 4
  // exactly when 2*t + o is
  function automatic logic leap_bcd(bcd_t yr);
    logic [3:0] ones;
    ones = yr[3:0];
    if (yr[4]) return (ones == 4'd2) || (ones == 4'd6);
    else       return (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
  endfunction

  function automatic bcd_t month_last(bcd_t mon, bcd_t yr);
    bcd_t r;
    case (mon)
      8'h02:                      r = leap_bcd(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRE_W = 15,
  parameter int TAP   = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_en,
  input  logic halt,
  input  logic clear,
  output logic tick,
  output logic sq
);
  localparam logic [PRE_W-1:0] CNT_MAX = '1;

  logic [PRE_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (clear)           cnt <= '0;
    else if (osc_en && !halt) cnt <= cnt + 1'b1;
  end

  assign tick = osc_en && !halt && (cnt == CNT_MAX);
  assign sq   = cnt[TAP];
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_pkg::*;
#(
  parameter bcd_t FLOOR = 8'h00
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  bcd_t ld_val,
  input  logic step,
  input  bcd_t last,
  output bcd_t val,
  output logic wrap
);
  bcd_t inc;

  always_comb begin
    if (val[3:0] == 4'd9) inc = {val[7:4] + 4'd1, 4'd0};
    else                  inc = {val[7:4], val[3:0] + 4'd1};
  end

  assign wrap = step && (val == last);

  always_ff @(posedge clk) begin
    if (rst)       val <= FLOOR;
    else if (load) val <= ld_val;
    else if (step) val <= (val == last) ? FLOOR : inc;
  end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int PRE_W = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       osc_en,
  input  logic       osc_stop,
  input  logic       freq_test,
  input  logic       load,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [7:0] ld_dow,
  input  logic [7:0] ld_date,
  input  logic [7:0] ld_month,
  input  logic [7:0] ld_year,
  input  logic [7:0] ld_cent,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic [7:0] cent_o
);
  // prescaler bit that toggles at 1/64 of the enable rate (512 Hz at 32768 Hz);
  // PRE_W must be at least 10
  localparam int TAP = PRE_W - 10;

  logic                tick;
  logic                sq;
  logic [NF-1:0]       step;
  logic [NF-1:0]       wrap;
  logic [NF-1:0][7:0]  fval;
  logic [NF-1:0][7:0]  last;
  logic [NF-1:0][7:0]  ld_arr;
  logic [7:0]          sec_true;

  rtc_prescaler #(.PRE_W(PRE_W), .TAP(TAP)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .osc_en (osc_en),
    .halt   (osc_stop),
    .clear  (load),
    .tick   (tick),
    .sq     (sq)
  );

  assign ld_arr = {ld_cent, ld_year, ld_month, ld_date,
                   ld_dow, ld_hour, ld_min, ld_sec};

  // carry routing: day of week and date both hang off the hour wrap
  assign step[F_SEC]   = tick;
  assign step[F_MIN]   = wrap[F_SEC];
  assign step[F_HOUR]  = wrap[F_MIN];
  assign step[F_DOW]   = wrap[F_HOUR];
  assign step[F_DATE]  = wrap[F_HOUR];
  assign step[F_MONTH] = wrap[F_DATE];
  assign step[F_YEAR]  = wrap[F_MONTH];
  assign step[F_CENT]  = wrap[F_YEAR];

  always_comb begin
    for (int i = 0; i < NF; i++) last[i] = LAST_TBL[i];
    last[F_DATE] = month_last(fval[F_MONTH], fval[F_YEAR]);
  end

  for (genvar i = 0; i < NF; i++) begin : g_fld
    rtc_bcd_field #(.FLOOR(FLOOR_TBL[i])) u_fld (
      .clk    (clk),
      .rst    (rst),
      .load   (load),
      .ld_val (ld_arr[i]),
      .step   (step[i]),
      .last   (last[i]),
      .val    (fval[i]),
      .wrap   (wrap[i])
    );
  end

  assign sec_true = fval[F_SEC];
  assign sec_o    = {sec_true[7:1], (freq_test && !osc_stop) ? sq : sec_true[0]};
  assign min_o    = fval[F_MIN];
  assign hour_o   = fval[F_HOUR];
  assign dow_o    = fval[F_DOW];
  assign date_o   = fval[F_DATE];
  assign month_o  = fval[F_MONTH];
  assign year_o   = fval[F_YEAR];
  assign cent_o   = fval[F_CENT];
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       load,
  input logic       osc_stop,
  input logic       tick,
  input logic [7:0] ld_sec,
  input logic [7:0] ld_cent,
  input logic [7:0] sec,
  input logic [7:0] min,
  input logic [7:0] hour,
  input logic [7:0] dow,
  input logic [7:0] date,
  input logic [7:0] month,
  input logic [7:0] year,
  input logic [7:0] cent
);
  assert_load_fields_R9: assert property (@(posedge clk) disable iff (rst)
    load |=> (sec == $past(ld_sec)) && (cent == $past(ld_cent)));

  assert_load_no_tick_R9: assert property (@(posedge clk) disable iff (rst)
    load |=> !tick);

  assert_stop_no_tick_R4: assert property (@(posedge clk) disable iff (rst)
    osc_stop |-> !tick);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(sec) && $stable(min) && $stable(hour) &&
                         $stable(dow) && $stable(date) && $stable(month) &&
                         $stable(year) && $stable(cent));

  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && sec == 8'h59) |=> sec == 8'h00);

  assert_day_turn_R8: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && sec == 8'h59 && min == 8'h59 && hour == 8'h23)
      |=> (dow != $past(dow)) && (date != $past(date)) && hour == 8'h00);
endmodule

bind bcd_rtc_core rtc_core_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .load     (load),
  .osc_stop (osc_stop),
  .tick     (tick),
  .ld_sec   (ld_sec),
  .ld_cent  (ld_cent),
  .sec      (sec_true),
  .min      (min_o),
  .hour     (hour_o),
  .dow      (dow_o),
  .date     (date_o),
  .month    (month_o),
  .year     (year_o),
  .cent     (cent_o)
);

// File: tb/sim_bcd_rtc_core.sv
`timescale 1ns/1ps
module sim_bcd_rtc_core;
  localparam int PW   = 10;
  localparam int PMAX = (1 << PW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_en = 1'b0, osc_stop = 1'b0, freq_test = 1'b0, load = 1'b0;
  logic [7:0] ld_sec = 0, ld_min = 0, ld_hour = 0, ld_dow = 0;
  logic [7:0] ld_date = 0, ld_month = 0, ld_year = 0, ld_cent = 0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o, cent_o;

  int n_chk = 0, n_fail = 0;
  int m [8];
  int mpre = 0;

  always #2 clk = ~clk;

  bcd_rtc_core #(.PRE_W(PW)) u0 (
    .clk(clk), .rst(rst), .osc_en(osc_en), .osc_stop(osc_stop),
    .freq_test(freq_test), .load(load),
    .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_dow(ld_dow),
    .ld_date(ld_date), .ld_month(ld_month), .ld_year(ld_year), .ld_cent(ld_cent),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o), .cent_o(cent_o)
  );

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int from_bcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int days_in(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic advance();
    if (m[0] != 59) begin m[0]++; return; end
    m[0] = 0;
    if (m[1] != 59) begin m[1]++; return; end
    m[1] = 0;
    if (m[2] != 23) begin m[2]++; return; end
    m[2] = 0;
    m[3] = (m[3] == 7) ? 1 : m[3] + 1;
    if (m[4] != days_in(m[5], m[6])) begin m[4]++; return; end
    m[4] = 1;
    if (m[5] != 12) begin m[5]++; return; end
    m[5] = 1;
    if (m[6] != 99) begin m[6]++; return; end
    m[6] = 0;
    m[7] = (m[7] == 39) ? 0 : m[7] + 1;
  endtask

  function automatic logic [63:0] exp_vec();
    logic [7:0] s;
    s = to_bcd(m[0]);
    if (freq_test && !osc_stop) s[0] = mpre[0];   // tap bit is PW-10 = 0
    return {to_bcd(m[7]), to_bcd(m[6]), to_bcd(m[5]), to_bcd(m[4]),
            to_bcd(m[3]), to_bcd(m[2]), to_bcd(m[1]), s};
  endfunction

  function automatic logic [63:0] act_vec();
    return {cent_o, year_o, month_o, date_o, dow_o, hour_o, min_o, sec_o};
  endfunction

  task automatic cyc();
    @(posedge clk);
    if (rst) begin
      m = '{0, 0, 0, 1, 1, 1, 0, 0};
      mpre = 0;
    end else if (load) begin
      m = '{from_bcd(ld_sec), from_bcd(ld_min), from_bcd(ld_hour), from_bcd(ld_dow),
            from_bcd(ld_date), from_bcd(ld_month), from_bcd(ld_year), from_bcd(ld_cent)};
      mpre = 0;
    end else if (osc_en && !osc_stop) begin
      if (mpre == PMAX) begin mpre = 0; advance(); end
      else mpre++;
    end
    #1;
  endtask

  task automatic report(string req, logic [63:0] a, logic [63:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  // runs n cycles comparing every cycle; counts as one check
  task automatic run(int n, string req);
    logic [63:0] fa, fe;
    bit bad = 0;
    for (int i = 0; i < n; i++) begin
      cyc();
      if (!bad && act_vec() !== exp_vec()) begin
        bad = 1; fa = act_vec(); fe = exp_vec();
      end
    end
    n_chk++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, fa, fe);
    end
  endtask

  task automatic set_all(int s, int mi, int h, int dw, int dt, int mo, int y, int c);
    ld_sec = to_bcd(s);  ld_min = to_bcd(mi); ld_hour = to_bcd(h);  ld_dow = to_bcd(dw);
    ld_date = to_bcd(dt); ld_month = to_bcd(mo); ld_year = to_bcd(y); ld_cent = to_bcd(c);
    load = 1'b1;
    cyc();
    load = 1'b0;
  endtask

  task automatic chk8(string req, logic [7:0] a, logic [7:0] e);
    report(req, {56'd0, a}, {56'd0, e});
  endtask

  initial begin
    #(4 * 190000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1742));
    for (int i = 0; i < 3; i++) cyc();
    rst = 1'b0;
    report("R1 reset values", act_vec(), 64'h00_00_01_01_01_00_00_00);

    osc_en = 1'b1;
    // R2 R3 R8 R10: full rollover of every field
    set_all(59, 59, 23, 7, 31, 12, 99, 39);
    run(PMAX + 5, "R10 R8 R3 R2 full rollover");
    report("R10 wrap to 00:00:00 01/01/00/00",
           {cent_o, year_o, month_o, date_o, dow_o, hour_o, min_o, sec_o},
           64'h00_00_01_01_01_00_00_00 | 64'(sec_o));
    // R10 year 99 -> century carry without century wrap
    set_all(59, 59, 23, 3, 31, 12, 99, 20);
    run(PMAX + 3, "R10 century carry");
    chk8("R10 century 21", cent_o, 8'h21);
    // R2 minute carry only
    set_all(59, 41, 5, 2, 10, 3, 15, 20);
    run(PMAX + 3, "R2 minute carry");
    chk8("R2 minutes 42", min_o, 8'h42);
    // R6 thirty-day and thirty-one-day months
    set_all(59, 59, 23, 1, 30, 4, 11, 20);
    run(PMAX + 3, "R6 April 30 end");
    chk8("R6 month 05", month_o, 8'h05);
    set_all(59, 59, 23, 1, 30, 1, 11, 20);
    run(PMAX + 3, "R6 January 30 to 31");
    chk8("R6 date 31", date_o, 8'h31);
    set_all(59, 59, 23, 1, 31, 1, 11, 20);
    run(PMAX + 3, "R6 January 31 end");
    // R7 February
    set_all(59, 59, 23, 1, 28, 2, 23, 20);
    run(PMAX + 3, "R7 Feb 28 non-leap");
    chk8("R7 month 03", month_o, 8'h03);
    set_all(59, 59, 23, 1, 28, 2, 24, 20);
    run(PMAX + 3, "R7 Feb 28 leap");
    chk8("R7 date 29", date_o, 8'h29);
    set_all(59, 59, 23, 1, 28, 2, 0, 20);
    run(PMAX + 3, "R7 Feb 28 year 00");
    set_all(59, 59, 23, 1, 28, 2, 10, 20);
    run(PMAX + 3, "R7 Feb 28 year 10");
    set_all(59, 59, 23, 6, 29, 2, 12, 20);
    run(PMAX + 3, "R7 Feb 29 year 12");
    // R11 out-of-range hour
    set_all(59, 59, 24, 1, 5, 5, 5, 20);
    run(PMAX + 3, "R11 hour 24 -> 25");
    chk8("R11 hour 25", hour_o, 8'h25);
    // R4 stop freezes, resume keeps phase
    set_all(10, 0, 0, 1, 1, 1, 0, 20);
    run(600, "R4 before stop");
    osc_stop = 1'b1;
    run(3000, "R4 frozen");
    chk8("R4 seconds held", sec_o, 8'h10);
    osc_stop = 1'b0;
    run(PMAX + 10, "R4 resume");
    chk8("R4 seconds 11", sec_o, 8'h11);
    // R5 frequency test
    freq_test = 1'b1;
    run(200, "R5 square wave");
    osc_stop = 1'b1;
    run(20, "R5 stopped shows true bit");
    osc_stop = 1'b0;
    freq_test = 1'b0;
    // R9 load in the tick cycle, then a full second
    set_all(20, 0, 0, 1, 1, 1, 0, 20);
    run(PMAX, "R9 reach terminal count");
    set_all(30, 1, 2, 3, 4, 5, 6, 7);
    chk8("R9 load wins over tick", sec_o, 8'h30);
    run(PMAX, "R9 no tick before a full second");
    chk8("R9 still 30", sec_o, 8'h30);
    run(1, "R9 tick after a full second");
    chk8("R9 seconds 31", sec_o, 8'h31);
    // R12 gapped enables
    set_all(0, 0, 0, 1, 1, 1, 0, 20);
    for (int k = 0; k < 2600; k++) begin
      osc_en = ($urandom % 3) != 0;
      run(1, "R12 gapped enables");
    end
    osc_en = 1'b1;
    // mixed random loads and controls
    for (int k = 0; k < 24; k++) begin
      int mo, yr;
      mo = 1 + $urandom % 12; yr = $urandom % 100;
      set_all(55 + $urandom % 5, $urandom % 2 ? 59 : $urandom % 60,
              $urandom % 2 ? 23 : $urandom % 24, 1 + $urandom % 7,
              days_in(mo, yr) - ($urandom % 2), mo, yr, $urandom % 40);
      freq_test = $urandom % 2;
      for (int j = 0; j < 6; j++) begin
        osc_stop = ($urandom % 8) == 0;
        osc_en   = ($urandom % 4) != 0;
        run(400, "R12 random mix");
      end
      osc_stop = 1'b0;
      osc_en = 1'b1;
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule